// File: doc/BRIEF.md
# RTC Interrupt Flag and Control Logic

This block holds the interrupt side of a real-time clock: a control register that carries a freeze bit and three interrupt enables, and a read-only status register that reports three event flags and a summary request bit. The time counters and the frequency divider live elsewhere. They signal this block through three single-cycle pulses: an update finished, the selected divider tap toggled, and the alarm matched. The block turns those pulses into sticky flags, qualifies each flag with its enable, and drives one interrupt request line.

A host reaches both registers through a simple register port that has an address, write data, a write strobe, a read strobe and combinational read data. A read of the status register returns the flags as they stand and then clears them. Three resets act on the block. A power-up reset clears everything. A host-domain reset clears the update and periodic paths. A RAM/time valid input, while low, holds the alarm enable and alarm flag at zero.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After power-up reset (`pwr_rst_n` low), the control and status registers read 0x00, and `irq` and `freeze` are 0.
- R2: Address 0x0B is the control register. A write stores bit 7 = SET, bit 6 = periodic enable, bit 5 = alarm enable, bit 4 = update enable. Bits 3:0 always read 0. `rdata` is 0x00 in any cycle that does not read 0x0B or 0x0C.
- R3: Address 0x0C is the status register. It reads bit 7 = request, bit 6 = periodic flag, bit 5 = alarm flag, bit 4 = update flag, and bits 3:0 = 0. Writes to it have no effect.
- R4: `irq` is 1 exactly when (update enable and update flag) or (alarm enable and alarm flag) or (periodic enable and periodic flag) holds. Status bit 7 always equals `irq`.
- R5: A status read returns the flag values from before the read. One cycle later all three flags and `irq` are 0, unless an event arrived in the read cycle.
- R6: An event pulse in the same cycle as a status read sets its flag, so the next status read shows it.
- R7: `upd_evt` sets the update flag and `tap_evt` sets the periodic flag one cycle later. This happens whatever the enables are.
- R8: When `rate_sel` is 0, `tap_evt` has no effect and the periodic flag stays 0.
- R9: `alm_evt` sets the alarm flag while `ram_valid` is 1. While `ram_valid` is 0, the alarm enable and alarm flag are held at 0, and writes to the alarm enable are lost.
- R10: `host_rst` clears the update enable, periodic enable, update flag and periodic flag. It leaves SET, the alarm enable and the alarm flag unchanged.
- R11: `freeze` equals SET. Only power-up reset or a control write changes it.
- R12: A flag that sets while its enable is off raises `irq` as soon as a control write turns that enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-up reset, asynchronous, active low |
| host_rst | input | 1 | Host-domain reset, synchronous, active high |
| ram_valid | input | 1 | RAM/time valid; low holds the alarm path cleared |
| addr | input | AW | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; a status read clears the flags |
| rdata | output | 8 | Combinational read data |
| upd_evt | input | 1 | Update-ended pulse |
| tap_evt | input | 1 | Divider tap transition pulse |
| alm_evt | input | 1 | Alarm match pulse |
| rate_sel | input | 4 | Periodic rate select; 0 disables the periodic source |
| irq | output | 1 | Interrupt request |
| freeze | output | 1 | Freeze user time copy (SET) |

## Verification
Most internal state in this block is visible at `irq` in the same cycle it changes. A flag or enable that holds a wrong value is therefore caught on the cycle after the bad update, as soon as its partner bit is set. A flag that is wrong while its enable is off shows up only on the next status read. For this reason the bench reads the status register often, and it compares `irq`, `freeze` and `rdata` against a reference model on every clock. Same-cycle collisions are the places where a wrong priority would hide: event against read, host reset against event, and a low valid bit against a write. Both directed and random stimulus drive those collisions.

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = AW'('h0B),
  parameter logic [AW-1:0] STAT_ADDR = AW'('h0C)
) (
  input  logic          clk,
  input  logic          pwr_rst_n,
  input  logic          host_rst,
  input  logic          ram_valid,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [7:0]    rdata,
  input  logic          upd_evt,
  input  logic          tap_evt,
  input  logic          alm_evt,
  input  logic [3:0]    rate_sel,
  output logic          irq,
  output logic          freeze
);

  logic set_q, uie_q, aie_q, pie_q;
  logic uf_q, af_q, pf_q;

  logic ctrl_wr, ctrl_rd, stat_rd, tap_live;
  assign ctrl_wr  = wr_en && (addr == CTRL_ADDR);
  assign ctrl_rd  = rd_en && (addr == CTRL_ADDR);
  assign stat_rd  = rd_en && (addr == STAT_ADDR);
  assign tap_live = tap_evt && (rate_sel != 4'd0);

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      set_q <= 1'b0;
      uie_q <= 1'b0;
      pie_q <= 1'b0;
      aie_q <= 1'b0;
    end else begin
      if (ctrl_wr) set_q <= wdata[7];
      if (host_rst) begin
        uie_q <= 1'b0;
        pie_q <= 1'b0;
      end else if (ctrl_wr) begin
        uie_q <= wdata[4];
        pie_q <= wdata[6];
      end
      if (!ram_valid)   aie_q <= 1'b0;
      else if (ctrl_wr) aie_q <= wdata[5];
    end
  end

  always_ff @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      uf_q <= 1'b0;
      pf_q <= 1'b0;
      af_q <= 1'b0;
    end else begin
      if (host_rst)     uf_q <= 1'b0;
      else if (upd_evt) uf_q <= 1'b1;
      else if (stat_rd) uf_q <= 1'b0;

      if (host_rst)      pf_q <= 1'b0;
      else if (tap_live) pf_q <= 1'b1;
      else if (stat_rd)  pf_q <= 1'b0;

      if (!ram_valid)   af_q <= 1'b0;
      else if (alm_evt) af_q <= 1'b1;
      else if (stat_rd) af_q <= 1'b0;
    end
  end

  assign irq    = (uie_q & uf_q) | (aie_q & af_q) | (pie_q & pf_q);
  assign freeze = set_q;

  always_comb begin
    rdata = 8'h00;
    if (ctrl_rd)      rdata = {set_q, pie_q, aie_q, uie_q, 4'b0000};
    else if (stat_rd) rdata = {irq, pf_q, af_q, uf_q, 4'b0000};
  end

endmodule

// File: rtl/rtc_irq_ctrl_chk.sv
module rtc_irq_ctrl_chk #(
  parameter int AW = 8,
  parameter logic [AW-1:0] CTRL_ADDR = AW'('h0B),
  parameter logic [AW-1:0] STAT_ADDR = AW'('h0C)
) (
  input logic          clk,
  input logic          pwr_rst_n,
  input logic          host_rst,
  input logic          ram_valid,
  input logic [AW-1:0] addr,
  input logic          wr_en,
  input logic          rd_en,
  input logic [7:0]    rdata,
  input logic          upd_evt,
  input logic          tap_evt,
  input logic          alm_evt,
  input logic          irq,
  input logic          freeze
);

  logic stat_rd, ctrl_wr;
  assign stat_rd = rd_en && (addr == STAT_ADDR);
  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

  // R5
  read_clears_irq_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (stat_rd && !upd_evt && !tap_evt && !alm_evt) |=> !irq);

  // R4
  status_bit7_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    stat_rd |-> (rdata[7] == irq));

  // R12
  irq_cause_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    $rose(irq) |-> $past(upd_evt || tap_evt || alm_evt || ctrl_wr));

  // R9
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !ram_valid |=> !(stat_rd && rdata[5]));

  // R10
  host_rst_flags_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    (host_rst && !upd_evt) |=> !(stat_rd && rdata[4]));

  // R11
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    !ctrl_wr |=> $stable(freeze));

  // R3
  low_nibble_chk: assert property (@(posedge clk) disable iff (!pwr_rst_n)
    rdata[3:0] == 4'h0);

endmodule

bind rtc_irq_ctrl rtc_irq_ctrl_chk #(
  .AW(AW), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .host_rst(host_rst), .ram_valid(ram_valid),
  .addr(addr), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
  .upd_evt(upd_evt), .tap_evt(tap_evt), .alm_evt(alm_evt),
  .irq(irq), .freeze(freeze)
);

// File: tb/rtc_irq_ctrl_test.sv
module rtc_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       pwr_rst_n = 1'b0;
  logic       host_rst = 1'b0;
  logic       ram_valid = 1'b1;
  logic [7:0] addr = 8'h00;
  logic [7:0] wdata = 8'h00;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [7:0] rdata;
  logic       upd_evt = 1'b0;
  logic       tap_evt = 1'b0;
  logic       alm_evt = 1'b0;
  logic [3:0] rate_sel = 4'd6;
  logic       irq;
  logic       freeze;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2 clk = ~clk;

  rtc_irq_ctrl uut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .host_rst(host_rst), .ram_valid(ram_valid),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata),
    .upd_evt(upd_evt), .tap_evt(tap_evt), .alm_evt(alm_evt), .rate_sel(rate_sel),
    .irq(irq), .freeze(freeze)
  );

  // behavioural reference state
  bit m_set, m_uie, m_aie, m_pie, m_uf, m_af, m_pf;

  function automatic bit m_irq();
    return (m_uie && m_uf) || (m_aie && m_af) || (m_pie && m_pf);
  endfunction

  always @(posedge clk or negedge pwr_rst_n) begin
    if (!pwr_rst_n) begin
      {m_set, m_uie, m_aie, m_pie, m_uf, m_af, m_pf} = '0;
    end else begin
      bit cw, sr;
      cw = wr_en && addr == 8'h0B;
      sr = rd_en && addr == 8'h0C;
      if (cw) m_set = wdata[7];
      if (host_rst) begin m_uie = 0; m_pie = 0; end
      else if (cw) begin m_uie = wdata[4]; m_pie = wdata[6]; end
      if (!ram_valid) m_aie = 0; else if (cw) m_aie = wdata[5];
      if (host_rst) m_uf = 0; else if (upd_evt) m_uf = 1; else if (sr) m_uf = 0;
      if (host_rst) m_pf = 0; else if (tap_evt && rate_sel != 0) m_pf = 1; else if (sr) m_pf = 0;
      if (!ram_valid) m_af = 0; else if (alm_evt) m_af = 1; else if (sr) m_af = 0;
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #1;
    if (!done) begin
      logic [7:0] er;
      er = 8'h00;
      if (rd_en && addr == 8'h0B) er = {m_set, m_pie, m_aie, m_uie, 4'h0};
      else if (rd_en && addr == 8'h0C) er = {m_irq(), m_pf, m_af, m_uf, 4'h0};
      chk("R4 irq model", {7'd0, irq}, {7'd0, m_irq()});
      chk("R11 freeze model", {7'd0, freeze}, {7'd0, m_set});
      chk("R2/R3 rdata model", rdata, er);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic pulse(input bit u, input bit t, input bit a);
    @(negedge clk); upd_evt = u; tap_evt = t; alm_evt = a;
    @(negedge clk); upd_evt = 0; tap_evt = 0; alm_evt = 0;
  endtask

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    pwr_rst_n = 1;
    rd(8'h0B, d); chk("R1 ctrl after reset", d, 8'h00);
    rd(8'h0C, d); chk("R1 status after reset", d, 8'h00);
    chk("R1 irq/freeze", {6'd0, irq, freeze}, 8'h00);

    wr(8'h0B, 8'hFF);
    rd(8'h0B, d); chk("R2 ctrl readback", d, 8'hF0);
    chk("R11 freeze set", {7'd0, freeze}, 8'h01);
    wr(8'h0B, 8'h00);

    wr(8'h0C, 8'hFF);
    rd(8'h0C, d); chk("R3 status write ignored", d, 8'h00);

    pulse(1, 0, 0);
    chk("R12 irq off while disabled", {7'd0, irq}, 8'h00);
    rd(8'h0C, d); chk("R7 update flag", d, 8'h10);
    rd(8'h0C, d); chk("R5 cleared by read", d, 8'h00);

    rate_sel = 4'd6;
    pulse(0, 1, 0);
    wr(8'h0B, 8'h40);
    chk("R12 enable raises irq", {7'd0, irq}, 8'h01);
    rd(8'h0C, d); chk("R4 status with request", d, 8'hC0);
    chk("R5 irq drops after read", {7'd0, irq}, 8'h00);

    rate_sel = 4'd0;
    pulse(0, 1, 0);
    rd(8'h0C, d); chk("R8 rate zero", d, 8'h00);
    rate_sel = 4'd3;

    @(negedge clk); addr = 8'h0C; rd_en = 1; upd_evt = 1; #1 d = rdata;
    @(negedge clk); rd_en = 0; upd_evt = 0;
    chk("R6 read returns old", d, 8'h00);
    rd(8'h0C, d); chk("R6 event kept", d, 8'h10);

    wr(8'h0B, 8'h20);
    pulse(0, 0, 1);
    chk("R9 alarm irq", {7'd0, irq}, 8'h01);
    @(negedge clk); ram_valid = 0;
    @(negedge clk);
    chk("R9 invalid drops irq", {7'd0, irq}, 8'h00);
    rd(8'h0B, d); chk("R9 alarm enable held", d, 8'h00);
    wr(8'h0B, 8'h20);
    rd(8'h0B, d); chk("R9 write lost while invalid", d, 8'h00);
    pulse(0, 0, 1);
    rd(8'h0C, d); chk("R9 alarm flag held", d, 8'h00);
    ram_valid = 1;

    wr(8'h0B, 8'hF0);
    pulse(1, 1, 1);
    @(negedge clk); host_rst = 1;
    @(negedge clk); host_rst = 0;
    rd(8'h0B, d); chk("R10 ctrl after host reset", d, 8'hA0);
    rd(8'h0C, d); chk("R10 status after host reset", d, 8'hA0);
    chk("R11 freeze kept", {7'd0, freeze}, 8'h01);

    @(negedge clk); pwr_rst_n = 0;
    @(negedge clk); pwr_rst_n = 1;
    chk("R11 power reset clears freeze", {7'd0, freeze}, 8'h00);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      host_rst  = ($urandom % 40) == 0;
      ram_valid = ($urandom % 20) != 0;
      wr_en     = ($urandom % 6) == 0;
      rd_en     = ($urandom % 3) == 0;
      upd_evt   = ($urandom % 5) == 0;
      tap_evt   = ($urandom % 5) == 0;
      alm_evt   = ($urandom % 5) == 0;
      rate_sel  = 4'($urandom);
      wdata     = 8'($urandom);
      case ($urandom % 4)
        0, 1: addr = 8'h0C;
        2: addr = 8'h0B;
        default: addr = 8'($urandom);
      endcase
    end
    @(negedge clk);
    {host_rst, wr_en, rd_en, upd_evt, tap_evt, alm_evt} = '0;
    ram_valid = 1;
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule